// File: doc/BRIEF.md
# Vectored Nesting Interrupt Controller

This block collects interrupt events from a set of on-chip peripherals and from three external request pins, and presents one 3-bit request level to the processor. It answers interrupt-acknowledge cycles in one of two ways. It can drive a vector number onto the bus, or it can stay off the bus so that external logic supplies the vector. Software uses four 16-bit registers through a simple select/write/read port: a global mode register, a pending register, a mask register and an in-service register.

The three pins have two readings, chosen by the mode bit. In one reading they are a binary priority level. In the other they are three separate request lines for levels 7, 6 and 1, and each of these lines can be level- or edge-sensitive. All internal sources request at one fixed level. The highest-numbered unmasked pending source wins. The in-service register lets a new request nest above the one being serviced only when it has a higher source number.

Top module: `vnic_ctrl`

## Requirements
- R1: After reset the mode, pending, mask and in-service registers all read 0x0000, and `cpu_ipl` is 0.
- R2: Writing the mode register (select 0) stores bits 15:12, 10:8 and 7:5. The other bits always read 0.
- R3: With mode bit 15 = 0, the pins form a binary level. `cpu_ipl` is the larger of that level and the internal request level.
- R4: With mode bit 15 = 1, pin 2 requests level 7, pin 1 requests level 6 and pin 0 requests level 1. The highest active line sets the external level. A line whose trigger bit is 0 (bit 10 for level 7, bit 9 for level 6, bit 8 for level 1) follows its pin directly.
- R5: A line whose trigger bit is 1 latches a rising edge of its pin. The request stays after the pin falls. An acknowledge at that line's level clears the latch; a new edge in the same cycle keeps it set.
- R6: A set mask bit (select 2) stops its pending source from requesting. The pending bit (select 1) still reads 1.
- R7: Internal sources request at level INT_LVL (default 4). The highest-numbered unmasked pending source is the winner. Its vector is {mode bits 7:5, 5-bit source number}.
- R8: An acknowledge at INT_LVL while an internal request is active selects the internal winner. In the next cycle its in-service bit is set and its pending bit is clear, unless a new event for that source arrives in the same cycle.
- R9: An internal request is blocked while any in-service bit is set at an index equal to or above the winner's index.
- R10: Writing 1s to the pending or in-service register clears those bits. An event arriving in the same cycle wins over the clear.
- R11: For an acknowledge at level 7, 6 or 1 that does not select the internal winner, the block drives the vector {bits 7:5, 2'b11, level} when that level's vector-select bit is 0. The select bits are bit 14 for level 7, bit 13 for level 6 and bit 12 for level 1. When the bit is 1, or for any other level, `vec_oe` is 0 and `vec_num` is 0.
- R12: Until the mode register is first written, every driven vector is 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| reg_sel | input | 2 | Register select: 0 mode, 1 pending, 2 mask, 3 in-service |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| src_evt | input | NSRC | One pulse per internal peripheral event; sets the pending bit |
| req_pin | input | 3 | External request pins |
| cpu_ipl | output | 3 | Request level presented to the processor |
| iack | input | 1 | Acknowledge strobe, one cycle |
| iack_lvl | input | 3 | Level being acknowledged |
| vec_oe | output | 1 | Block drives a vector in this acknowledge |
| vec_num | output | 8 | Vector number (0 when not driven) |

## Verification
The embedded properties check several rules on every cycle. An internal winner is never masked and never sits below an in-service bit. The request level never falls below the external level. An internal acknowledge always leaves the winner in service. A write-1 to the in-service register clears those bits. An unprogrammed controller only drives 0x0F. A latched edge always shows as a request one cycle later. Other behaviour shows only in the bench's scenarios, with the reference model compared each cycle: the two readings of the pins, the priority order, the exact vector values, an edge request held after its pin falls, and the switch between driving a vector and leaving the bus to external logic.

// File: rtl/vnic_pkg.sv
package vnic_pkg;

   localparam int          REG_W       = 16;
   localparam logic [15:0] MODE_WMASK  = 16'hF7E0;
   localparam int          B_MODE      = 15;
   localparam int          B_VBASE_LO  = 5;
   localparam logic [7:0]  VEC_UNSET   = 8'h0F;

   typedef enum logic [1:0] {
      SEL_MODE = 2'd0,
      SEL_PEND = 2'd1,
      SEL_MASK = 2'd2,
      SEL_SERV = 2'd3
   } reg_sel_e;

   // dedicated line index -> priority level it carries
   function automatic logic [2:0] line_level(input int k);
      case (k)
         0:       return 3'd1;
         1:       return 3'd6;
         default: return 3'd7;
      endcase
   endfunction

   function automatic logic [2:0] lvl_max(input logic [2:0] a, input logic [2:0] b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/vnic_pin_front.sv
module vnic_pin_front
   import vnic_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] pin,
   input  logic       dedicated,
   input  logic [2:0] edge_en,
   input  logic [2:0] ack_hit,
   output logic [2:0] ext_lvl
);

   logic [2:0] line_act;

   generate
      for (genvar k = 0; k < 3; k++) begin : g_line
         logic pin_q;
         logic held;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pin_q <= 1'b0;
               held  <= 1'b0;
            end else begin
               pin_q <= pin[k];
               held  <= (held & ~ack_hit[k]) | (pin[k] & ~pin_q);
            end
         end

         assign line_act[k] = edge_en[k] ? held : pin[k];

         // R5: a rising edge is always captured for the next cycle
         p_edge_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pin[k] && !pin_q) |=> held);
      end
   endgenerate

   always_comb begin
      if (!dedicated)       ext_lvl = pin;
      else if (line_act[2]) ext_lvl = line_level(2);
      else if (line_act[1]) ext_lvl = line_level(1);
      else if (line_act[0]) ext_lvl = line_level(0);
      else                  ext_lvl = 3'd0;
   end

endmodule

// File: rtl/vnic_prio.sv
module vnic_prio #(
   parameter  int NSRC = 16,
   localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0] req,
   input  logic [NSRC-1:0] busy,
   output logic            hit,
   output logic [IW-1:0]   idx
);

   logic any;
   logic blk;

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
      blk = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         if (busy[i] && (i >= int'(idx))) blk = 1'b1;
      end
      hit = any & ~blk;
   end

endmodule

// File: rtl/vnic_ctrl.sv
module vnic_ctrl
   import vnic_pkg::*;
#(
   parameter  int NSRC    = 16,
   parameter  int INT_LVL = 4,
   localparam int IW      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      reg_sel,
   input  logic            reg_wr,
   input  logic [15:0]     reg_wdata,
   output logic [15:0]     reg_rdata,
   input  logic [NSRC-1:0] src_evt,
   input  logic [2:0]      req_pin,
   output logic [2:0]      cpu_ipl,
   input  logic            iack,
   input  logic [2:0]      iack_lvl,
   output logic            vec_oe,
   output logic [7:0]      vec_num
);

   generate
      if (NSRC < 2 || NSRC > REG_W) begin : g_bad_nsrc
         $error("vnic_ctrl: NSRC must be 2..16");
      end
      if (INT_LVL < 1 || INT_LVL > 7) begin : g_bad_lvl
         $error("vnic_ctrl: INT_LVL must be 1..7");
      end
   endgenerate

   localparam logic [2:0] ILVL = 3'(INT_LVL);

   logic [15:0]     mode_r;
   logic            based_r;
   logic [NSRC-1:0] pend_r, mask_r, serv_r;

   logic [2:0]      ext_lvl;
   logic            int_hit;
   logic [IW-1:0]   win;
   logic            ack_int;
   logic [2:0]      ack_hit;
   logic [2:0]      vsel_line, edge_line;
   logic [NSRC-1:0] win_1h;
   logic [2:0]      vbase;

   assign vsel_line = mode_r[14:12];
   assign edge_line = mode_r[10:8];
   assign vbase     = mode_r[B_VBASE_LO +: 3];

   vnic_pin_front u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (req_pin),
      .dedicated (mode_r[B_MODE]),
      .edge_en   (edge_line),
      .ack_hit   (ack_hit),
      .ext_lvl   (ext_lvl)
   );

   vnic_prio #(.NSRC(NSRC)) u_prio (
      .req  (pend_r & ~mask_r),
      .busy (serv_r),
      .hit  (int_hit),
      .idx  (win)
   );

   assign cpu_ipl = lvl_max(ext_lvl, int_hit ? ILVL : 3'd0);
   assign ack_int = iack && int_hit && (iack_lvl == ILVL);
   assign win_1h  = ack_int ? (NSRC'(1) << win) : '0;

   generate
      for (genvar k = 0; k < 3; k++) begin : g_ack
         assign ack_hit[k] = iack && !ack_int && (iack_lvl == line_level(k));
      end
   endgenerate

   // acknowledge response
   always_comb begin
      vec_oe  = 1'b0;
      vec_num = 8'h00;
      if (ack_int) begin
         vec_oe  = 1'b1;
         vec_num = {vbase, 5'(win)};
      end else if (|(ack_hit & ~vsel_line)) begin
         vec_oe  = 1'b1;
         vec_num = {vbase, 2'b11, iack_lvl};
      end
      if (vec_oe && !based_r) vec_num = VEC_UNSET;
   end

   // register file
   logic wr_mode, wr_pend, wr_mask, wr_serv;
   assign wr_mode = reg_wr && (reg_sel == SEL_MODE);
   assign wr_pend = reg_wr && (reg_sel == SEL_PEND);
   assign wr_mask = reg_wr && (reg_sel == SEL_MASK);
   assign wr_serv = reg_wr && (reg_sel == SEL_SERV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_r  <= '0;
         based_r <= 1'b0;
         pend_r  <= '0;
         mask_r  <= '0;
         serv_r  <= '0;
      end else begin
         if (wr_mode) begin
            mode_r  <= reg_wdata & MODE_WMASK;
            based_r <= 1'b1;
         end
         if (wr_mask) mask_r <= reg_wdata[NSRC-1:0];
         pend_r <= (pend_r & ~(wr_pend ? reg_wdata[NSRC-1:0] : '0) & ~win_1h) | src_evt;
         serv_r <= (serv_r & ~(wr_serv ? reg_wdata[NSRC-1:0] : '0)) | win_1h;
      end
   end

   always_comb begin
      case (reg_sel)
         SEL_MODE: reg_rdata = mode_r;
         SEL_PEND: reg_rdata = REG_W'(pend_r);
         SEL_MASK: reg_rdata = REG_W'(mask_r);
         default:  reg_rdata = REG_W'(serv_r);
      endcase
   end

   // R3: the request level never drops below the external level
   p_ipl_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ipl >= ext_lvl);

   // R6: a winning source is pending and unmasked
   p_win_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int_hit |-> (pend_r[win] && !mask_r[win]));

   // R9: nothing at or above the winner is in service
   p_nest_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      int_hit |-> ((serv_r >> win) == '0));

   // R8: an internal acknowledge leaves the winner in service
   p_ack_serv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_int |=> serv_r[$past(win)]);

   // R10: write-1 clears in-service bits when no acknowledge lands
   p_serv_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_serv && !ack_int) |=> ((serv_r & $past(reg_wdata[NSRC-1:0])) == '0));

   // R12: an unprogrammed controller drives only the fixed vector
   p_unset_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_oe && !based_r) |-> (vec_num == VEC_UNSET));

endmodule

// File: tb/vnic_ctrl_tb.sv
`timescale 1ns/1ps
module vnic_ctrl_tb;
   localparam int NSRC    = 16;
   localparam int INT_LVL = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      reg_sel = 2'd0;
   logic            reg_wr = 1'b0;
   logic [15:0]     reg_wdata = 16'h0;
   logic [15:0]     reg_rdata;
   logic [NSRC-1:0] src_evt = '0;
   logic [2:0]      req_pin = 3'd0;
   logic [2:0]      cpu_ipl;
   logic            iack = 1'b0;
   logic [2:0]      iack_lvl = 3'd0;
   logic            vec_oe;
   logic [7:0]      vec_num;

   always #2.5 clk = ~clk;

   vnic_ctrl #(.NSRC(NSRC), .INT_LVL(INT_LVL)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt),
      .req_pin(req_pin), .cpu_ipl(cpu_ipl), .iack(iack), .iack_lvl(iack_lvl),
      .vec_oe(vec_oe), .vec_num(vec_num)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   int    cycles = 0;
   string cur_req = "R1";

   // ---------------- reference model state ----------------
   int m_mode, m_pend, m_mask, m_serv;
   bit m_based;
   bit m_held [3];
   bit m_pinq [3];

   // model outputs
   int m_ipl, m_win, m_oe, m_vec, m_rd;
   bit m_ihit, m_ackint;
   bit m_ackline [3];

   function automatic int lvl_of(int k);
      return (k == 0) ? 1 : (k == 1) ? 6 : 7;
   endfunction

   function automatic void model_eval();
      int live, ext, vb;
      bit blk, act;
      live   = m_pend & ~m_mask & 16'hFFFF;
      m_win  = -1;
      for (int i = 0; i < NSRC; i++) if ((live >> i) & 1) m_win = i;
      blk = 0;
      if (m_win >= 0)
         for (int i = m_win; i < NSRC; i++) if ((m_serv >> i) & 1) blk = 1;
      m_ihit = (m_win >= 0) && !blk;
      ext = 0;
      if (((m_mode >> 15) & 1) == 0) ext = req_pin;
      else begin
         for (int k = 0; k < 3; k++) begin
            act = ((m_mode >> (8 + k)) & 1) ? m_held[k] : req_pin[k];
            if (act && lvl_of(k) > ext) ext = lvl_of(k);
         end
      end
      m_ipl = ext;
      if (m_ihit && INT_LVL > m_ipl) m_ipl = INT_LVL;
      m_ackint = iack && m_ihit && (iack_lvl == INT_LVL);
      vb = (m_mode >> 5) & 7;
      m_oe = 0; m_vec = 0;
      for (int k = 0; k < 3; k++) m_ackline[k] = iack && !m_ackint && (iack_lvl == lvl_of(k));
      if (m_ackint) begin
         m_oe = 1; m_vec = vb * 32 + m_win;
      end else begin
         for (int k = 0; k < 3; k++)
            if (m_ackline[k] && ((m_mode >> (12 + k)) & 1) == 0) begin
               m_oe = 1; m_vec = vb * 32 + 24 + lvl_of(k);
            end
      end
      if (m_oe && !m_based) m_vec = 8'h0F;
      case (reg_sel)
         2'd0: m_rd = m_mode;
         2'd1: m_rd = m_pend;
         2'd2: m_rd = m_mask;
         default: m_rd = m_serv;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_pend = 0; m_mask = 0; m_serv = 0; m_based = 0;
         for (int k = 0; k < 3; k++) begin m_held[k] = 0; m_pinq[k] = 0; end
      end else begin
         int clr, ack1h;
         model_eval();
         ack1h = m_ackint ? (1 << m_win) : 0;
         for (int k = 0; k < 3; k++) begin
            m_held[k] = (m_held[k] && !m_ackline[k]) || (req_pin[k] && !m_pinq[k]);
            m_pinq[k] = req_pin[k];
         end
         clr = (reg_wr && reg_sel == 2'd1) ? reg_wdata : 0;
         m_pend = ((m_pend & ~clr & ~ack1h) | src_evt) & 16'hFFFF;
         clr = (reg_wr && reg_sel == 2'd3) ? reg_wdata : 0;
         m_serv = ((m_serv & ~clr) | ack1h) & 16'hFFFF;
         if (reg_wr && reg_sel == 2'd2) m_mask = reg_wdata;
         if (reg_wr && reg_sel == 2'd0) begin m_mode = reg_wdata & 16'hF7E0; m_based = 1; end
      end
   end

   task automatic chk(string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   // compare away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         model_eval();
         chk("cpu_ipl", cpu_ipl, m_ipl);
         chk("reg_rdata", reg_rdata, m_rd);
         if (iack) begin
            chk("vec_oe", vec_oe, m_oe);
            chk("vec_num", vec_num, m_vec);
         end
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(int sel, int data);
      reg_sel = 2'(sel); reg_wdata = 16'(data); reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic evt(int mask);
      src_evt = NSRC'(mask);
      tick();
      src_evt = '0;
   endtask

   task automatic ack(int lvl);
      iack_lvl = 3'(lvl); iack = 1'b1;
      tick();
      iack = 1'b0;
   endtask

   task automatic show(int sel);
      reg_sel = 2'(sel);
      tick();
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1: reset contents
      cur_req = "R1";
      for (int s = 0; s < 4; s++) show(s);
      chk("ipl at reset", cpu_ipl, 0);

      // R12: vector before any mode write
      cur_req = "R12";
      evt(1 << 3); tick();
      ack(INT_LVL); show(3);
      // R10: clear in-service by writing 1
      cur_req = "R10";
      wr(3, 16'hFFFF); show(3);

      // R2: reserved bits read zero
      cur_req = "R2";
      wr(0, 16'hFFFF); show(0);
      wr(0, 16'h00A0); show(0);

      // R3: encoded pins
      cur_req = "R3";
      req_pin = 3'd6; tick(2);
      req_pin = 3'd2; evt(1 << 1); tick();
      ack(INT_LVL); wr(3, 16'hFFFF); req_pin = 3'd0; tick();

      // R7 / R8: highest number wins, acknowledge moves it to service
      cur_req = "R7";
      evt((1 << 2) | (1 << 9)); tick();
      cur_req = "R8";
      ack(INT_LVL); show(1); show(3);

      // R9: lower source blocked by source 9 in service
      cur_req = "R9";
      tick(2);
      evt(1 << 12); tick();
      ack(INT_LVL); tick();

      // R6: masked source stays pending but silent
      cur_req = "R6";
      wr(3, 16'hFFFF);
      wr(2, 16'hFFFF); evt(1 << 5); show(1); tick();
      wr(2, 16'h0000); tick();
      // R10: clear pending by writing 1
      cur_req = "R10";
      wr(1, 16'hFFFF); show(1);

      // R4: dedicated lines, level-sensitive
      cur_req = "R4";
      wr(0, 16'h80A0);
      req_pin = 3'b011; tick(2);
      req_pin = 3'b001; tick(2);
      req_pin = 3'b100; tick();

      // R11: internal vs external vector per level
      cur_req = "R11";
      ack(7); req_pin = 3'b010; ack(6); ack(1); ack(3);
      wr(0, 16'hA0A0); ack(6); ack(7);
      req_pin = 3'b000; tick();

      // R5: edge-triggered level 7 held until acknowledged
      cur_req = "R5";
      wr(0, 16'h84A0);
      req_pin = 3'b100; tick(); req_pin = 3'b000; tick(3);
      ack(7); tick(2);
      req_pin = 3'b100; iack_lvl = 3'd7; iack = 1'b1; tick(); iack = 1'b0;
      req_pin = 3'b000; tick(2); ack(7); tick(2);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule